// File: doc/BRIEF.md
# Virtually indexed, physically tagged data cache lookup

This block is the lookup path of a level-one data cache. A load presents its virtual address. The set is chosen from address bits that lie inside the page offset, so these bits need no translation. In the same cycle, a small fully associative translation buffer maps the virtual page number to a physical frame number. In the next cycle the frame number is compared against the stored tag of every way in the selected set. The block then reports hit or miss, the way that matched and the addressed data word.

The translation buffer is loaded through a write port. Missing lines are installed through a line-fill port: the line goes into a way that already holds the same tag, otherwise into an empty way, otherwise into a way picked by a free-running LFSR. A flush input invalidates every cache line and every translation entry in one cycle. The default build has 4 KB pages, 64-byte lines, 64 sets and 8 ways, which gives 32 KB.

Top module: `vipt_cache`

## Requirements
- R1: After reset, resp_valid is low and no translation entry or cache line is valid, so the first lookup reports a translation miss without a hit.
- R2: A request taken at a rising edge produces its response at the second rising edge after it. resp_valid is high for exactly one cycle per request and low otherwise.
- R3: The set index is req_va[PAGE_BITS-1:LINE_BITS] only. Two virtual pages that translate to the same frame therefore see the same cached line, in the same way and with the same data.
- R4: resp_hit is 1 only when the translation hits and a valid way of the indexed set holds a tag equal to the translated frame number. The stored tag is fill_pa[PA_BITS-1:PAGE_BITS]. In every other case resp_hit is 0.
- R5: When the translation misses, resp_tlb_miss is 1 and resp_hit is 0, even if the line is cached. Once the mapping is written, replaying the same address hits.
- R6: A translation write goes to the entry that already holds the same virtual page number. If there is none, it goes to the lowest-numbered invalid entry. If there is none of those either, it goes to the entry at a replacement pointer. The pointer is 0 after reset and advances by one, wrapping, only on that last kind of write.
- R7: A line fill writes the set given by fill_pa[PAGE_BITS-1:LINE_BITS]. The way chosen is, in order of preference: the way already holding the same tag, the lowest-numbered invalid way, or a way chosen by the LFSR. fill_pa[LINE_BITS-1:0] is ignored.
- R8: flush clears every valid bit in the cache and in the translation buffer in one cycle. A fill or translation write in the same cycle as flush is dropped.
- R9: No two valid ways of one set ever hold the same tag, so at most one way matches a lookup.
- R10: On a hit, resp_way is the index of the matching way. resp_data is word k of that line, where k = req_va[LINE_BITS-1:log2(WORD_BITS/8)] and word k is fill_line[k*WORD_BITS +: WORD_BITS]. The byte bits below the word are ignored. On a miss, resp_way and resp_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all lines and translation entries |
| req_valid | input | 1 | Lookup request |
| req_va | input | VA_BITS | Virtual load address |
| resp_valid | output | 1 | Response valid, two cycles after the request |
| resp_hit | output | 1 | Line found |
| resp_tlb_miss | output | 1 | Translation not found |
| resp_way | output | log2(WAYS) | Matching way |
| resp_data | output | WORD_BITS | Addressed word of the matching line |
| tlb_wr_valid | input | 1 | Translation write strobe |
| tlb_wr_vpn | input | VA_BITS-PAGE_BITS | Virtual page number to install |
| tlb_wr_pfn | input | PA_BITS-PAGE_BITS | Physical frame number to install |
| fill_valid | input | 1 | Line fill strobe |
| fill_pa | input | PA_BITS | Physical address of the line being filled |
| fill_line | input | 8<<LINE_BITS | Line contents, word 0 in the low bits |

## Verification
The bench builds the block with 64-byte pages, 16-byte lines, 4 sets, 2 ways, 2 translation entries, 32-bit words, a 10-bit virtual address and a 9-bit physical address. At this size the bench can read every word of every set, and it can fill both ways of a set and push it into LFSR replacement for several rounds. With only two translation entries, a third mapping forces pointer replacement, so same-page overwrite, invalid-first allocation and round-robin eviction all occur within a few writes. The eight-frame space makes aliasing of two virtual pages to one frame easy to set up.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

    localparam int LFSR_W = 16;

    // Maximal-length 16-bit Fibonacci LFSR step (taps 16,14,13,11).
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 36,
    parameter int PFN_W   = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic [PFN_W-1:0]   lk_pfn,
    input  logic               wr_valid,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    output logic [ENTRIES-1:0] ent_vld
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][VPN_W-1:0] vpn;
        logic [ENTRIES-1:0][PFN_W-1:0] pfn;
        logic [IDX_W-1:0]              ptr;
    } tlb_state_t;

    tlb_state_t st_d, st_q;
    logic [ENTRIES-1:0] match;
    logic               same_found, free_found;
    logic [IDX_W-1:0]   same_idx, free_idx, slot;

    // Associative match on the virtual page number.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = st_q.vld[e] && (st_q.vpn[e] == lk_vpn);
    end

    always_comb begin
        lk_hit = |match;
        lk_pfn = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) lk_pfn = lk_pfn | st_q.pfn[e];
        end
    end

    always_comb begin
        st_d       = st_q;
        same_found = 1'b0;
        same_idx   = '0;
        free_found = 1'b0;
        free_idx   = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (!st_q.vld[e]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(e);
            end
            if (st_q.vld[e] && st_q.vpn[e] == wr_vpn) begin
                same_found = 1'b1;
                same_idx   = IDX_W'(e);
            end
        end
        slot = same_found ? same_idx : (free_found ? free_idx : st_q.ptr);
        if (flush) begin
            st_d.vld = '0;
        end else if (wr_valid) begin
            st_d.vld[slot] = 1'b1;
            st_d.vpn[slot] = wr_vpn;
            st_d.pfn[slot] = wr_pfn;
            if (!same_found && !free_found) begin
                st_d.ptr = (st_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ent_vld = st_q.vld;

endmodule

// File: rtl/vipt_store.sv
module vipt_store #(
    parameter int SET_BITS = 6,
    parameter int WAYS     = 8,
    parameter int TAG_W    = 28,
    parameter int LINE_W   = 512
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic [SET_BITS-1:0]         rd_set,
    output logic [WAYS-1:0]             rd_vld,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
    output logic [WAYS-1:0][LINE_W-1:0] rd_lines,
    input  logic                        fill_valid,
    input  logic [SET_BITS-1:0]         fill_set,
    input  logic [TAG_W-1:0]            fill_tag,
    input  logic [LINE_W-1:0]           fill_line,
    output logic [(1<<SET_BITS)*WAYS-1:0] vld_all
);
    import vipt_pkg::*;

    localparam int SETS  = 1 << SET_BITS;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [LFSR_W-1:0]                    lfsr;
    } store_state_t;

    store_state_t st_d, st_q;
    logic [WAYS-1:0]   same_tag;
    logic [WAY_W-1:0]  victim;
    logic              fill_we;
    logic [LINE_W-1:0] line_mem [SETS*WAYS];

    always_comb begin
        st_d      = st_q;
        st_d.lfsr = lfsr_step(st_q.lfsr);
        for (int w = 0; w < WAYS; w++) begin
            same_tag[w] = st_q.vld[fill_set][w] && (st_q.tag[fill_set][w] == fill_tag);
        end
        // Lowest priority first: LFSR, then lowest invalid, then same tag.
        victim = st_q.lfsr[WAY_W-1:0];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!st_q.vld[fill_set][w]) victim = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (same_tag[w]) victim = WAY_W'(w);
        end
        fill_we = fill_valid && !flush;
        if (flush) begin
            st_d.vld = '0;
        end else if (fill_valid) begin
            st_d.vld[fill_set][victim] = 1'b1;
            st_d.tag[fill_set][victim] = fill_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.lfsr <= LFSR_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we) line_mem[{fill_set, victim}] <= fill_line;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_rd
        assign rd_vld[w]   = st_q.vld[rd_set][w];
        assign rd_tags[w]  = st_q.tag[rd_set][w];
        assign rd_lines[w] = line_mem[{rd_set, WAY_W'(w)}];
    end

    assign vld_all = st_q.vld;

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache #(
    parameter int PAGE_BITS   = 12,
    parameter int LINE_BITS   = 6,
    parameter int WAYS        = 8,
    parameter int TLB_ENTRIES = 8,
    parameter int VA_BITS     = 48,
    parameter int PA_BITS     = 40,
    parameter int WORD_BITS   = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         req_valid,
    input  logic [VA_BITS-1:0]           req_va,
    output logic                         resp_valid,
    output logic                         resp_hit,
    output logic                         resp_tlb_miss,
    output logic [$clog2(WAYS)-1:0]      resp_way,
    output logic [WORD_BITS-1:0]         resp_data,
    input  logic                         tlb_wr_valid,
    input  logic [VA_BITS-PAGE_BITS-1:0] tlb_wr_vpn,
    input  logic [PA_BITS-PAGE_BITS-1:0] tlb_wr_pfn,
    input  logic                         fill_valid,
    input  logic [PA_BITS-1:0]           fill_pa,
    input  logic [(8<<LINE_BITS)-1:0]    fill_line
);
    localparam int SET_BITS = PAGE_BITS - LINE_BITS;
    localparam int SETS     = 1 << SET_BITS;
    localparam int VPN_W    = VA_BITS - PAGE_BITS;
    localparam int PFN_W    = PA_BITS - PAGE_BITS;
    localparam int LINE_W   = 8 << LINE_BITS;
    localparam int WORDS    = LINE_W / WORD_BITS;
    localparam int WOFF_W   = $clog2(WORDS);
    localparam int WB_BITS  = $clog2(WORD_BITS / 8);
    localparam int WAY_W    = $clog2(WAYS);

    typedef struct packed {
        logic                                    valid;
        logic                                    tlb_hit;
        logic [PFN_W-1:0]                        pfn;
        logic [WOFF_W-1:0]                       woff;
        logic [WAYS-1:0]                         vld;
        logic [WAYS-1:0][PFN_W-1:0]              tags;
        logic [WAYS-1:0][WORDS-1:0][WORD_BITS-1:0] lines;
    } stage1_t;

    typedef struct packed {
        logic                 valid;
        logic                 hit;
        logic                 tlb_miss;
        logic [WAY_W-1:0]     way;
        logic [WORD_BITS-1:0] data;
    } resp_t;

    typedef struct packed {
        stage1_t s1;
        resp_t   rsp;
    } pipe_t;

    pipe_t st_d, st_q;

    logic                        tlb_hit;
    logic [PFN_W-1:0]            tlb_pfn;
    logic [TLB_ENTRIES-1:0]      tlb_vld;
    logic [WAYS-1:0]             rd_vld;
    logic [WAYS-1:0][PFN_W-1:0]  rd_tags;
    logic [WAYS-1:0][LINE_W-1:0] rd_lines;
    logic [SETS*WAYS-1:0]        line_vld;
    logic [WAYS-1:0]             s2_hits;

    vipt_tlb #(
        .ENTRIES (TLB_ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) i_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_vpn   (req_va[VA_BITS-1:PAGE_BITS]),
        .lk_hit   (tlb_hit),
        .lk_pfn   (tlb_pfn),
        .wr_valid (tlb_wr_valid),
        .wr_vpn   (tlb_wr_vpn),
        .wr_pfn   (tlb_wr_pfn),
        .ent_vld  (tlb_vld)
    );

    vipt_store #(
        .SET_BITS (SET_BITS),
        .WAYS     (WAYS),
        .TAG_W    (PFN_W),
        .LINE_W   (LINE_W)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .rd_set     (req_va[PAGE_BITS-1:LINE_BITS]),
        .rd_vld     (rd_vld),
        .rd_tags    (rd_tags),
        .rd_lines   (rd_lines),
        .fill_valid (fill_valid),
        .fill_set   (fill_pa[PAGE_BITS-1:LINE_BITS]),
        .fill_tag   (fill_pa[PA_BITS-1:PAGE_BITS]),
        .fill_line  (fill_line),
        .vld_all    (line_vld)
    );

    always_comb begin
        st_d = st_q;
        // Cycle 1: translation and set read run side by side.
        st_d.s1.valid   = req_valid;
        st_d.s1.tlb_hit = tlb_hit;
        st_d.s1.pfn     = tlb_pfn;
        st_d.s1.woff    = req_va[LINE_BITS-1:WB_BITS];
        st_d.s1.vld     = rd_vld;
        st_d.s1.tags    = rd_tags;
        st_d.s1.lines   = rd_lines;
        // Cycle 2: physical tag compare and way select.
        st_d.rsp.valid    = st_q.s1.valid;
        st_d.rsp.tlb_miss = st_q.s1.valid && !st_q.s1.tlb_hit;
        st_d.rsp.way      = '0;
        st_d.rsp.data     = '0;
        for (int w = 0; w < WAYS; w++) begin
            s2_hits[w] = st_q.s1.valid && st_q.s1.tlb_hit && st_q.s1.vld[w] &&
                         (st_q.s1.tags[w] == st_q.s1.pfn);
            if (s2_hits[w]) begin
                st_d.rsp.way  = WAY_W'(w);
                st_d.rsp.data = st_q.s1.lines[w][st_q.s1.woff];
            end
        end
        st_d.rsp.hit = |s2_hits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign resp_valid    = st_q.rsp.valid;
    assign resp_hit      = st_q.rsp.hit;
    assign resp_tlb_miss = st_q.rsp.tlb_miss;
    assign resp_way      = st_q.rsp.way;
    assign resp_data     = st_q.rsp.data;

endmodule

// File: rtl/vipt_cache_chk.sv
module vipt_cache_chk #(
    parameter int WAYS    = 8,
    parameter int SETS    = 64,
    parameter int ENTRIES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flush,
    input logic                 req_valid,
    input logic                 resp_valid,
    input logic                 resp_hit,
    input logic                 resp_tlb_miss,
    input logic [WAYS-1:0]      hits,
    input logic [SETS*WAYS-1:0] vld_all,
    input logic [ENTRIES-1:0]   tlb_vld
);
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ##2 resp_valid);

    p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid, 2));

    p_hit_needs_xlat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_hit |-> (resp_valid && !resp_tlb_miss));

    p_hit_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|hits) |=> resp_hit);

    p_single_way_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hits));

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_all == '0 && tlb_vld == '0));

endmodule

bind vipt_cache vipt_cache_chk #(
    .WAYS    (WAYS),
    .SETS    (SETS),
    .ENTRIES (TLB_ENTRIES)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .req_valid     (req_valid),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .resp_tlb_miss (resp_tlb_miss),
    .hits          (s2_hits),
    .vld_all       (line_vld),
    .tlb_vld       (tlb_vld)
);

// File: tb/test_vipt_cache.sv
module test_vipt_cache;
    localparam int PAGE_BITS = 6;
    localparam int LINE_BITS = 4;
    localparam int WAYS      = 2;
    localparam int TLBN      = 2;
    localparam int VA_BITS   = 10;
    localparam int PA_BITS   = 9;
    localparam int WORD_BITS = 32;
    localparam int LINE_W    = 8 << LINE_BITS;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 flush = 1'b0;
    logic                 req_valid = 1'b0;
    logic [VA_BITS-1:0]   req_va = '0;
    logic                 resp_valid, resp_hit, resp_tlb_miss;
    logic                 resp_way;
    logic [WORD_BITS-1:0] resp_data;
    logic                 tlb_wr_valid = 1'b0;
    logic [3:0]           tlb_wr_vpn = '0;
    logic [2:0]           tlb_wr_pfn = '0;
    logic                 fill_valid = 1'b0;
    logic [PA_BITS-1:0]   fill_pa = '0;
    logic [LINE_W-1:0]    fill_line = '0;

    int checks = 0;
    int errors = 0;

    logic        g_valid, g_hit, g_tm, g_way;
    logic [31:0] g_data;

    always #2 clk = ~clk;

    vipt_cache #(
        .PAGE_BITS   (PAGE_BITS),
        .LINE_BITS   (LINE_BITS),
        .WAYS        (WAYS),
        .TLB_ENTRIES (TLBN),
        .VA_BITS     (VA_BITS),
        .PA_BITS     (PA_BITS),
        .WORD_BITS   (WORD_BITS)
    ) i_vipt_cache (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush         (flush),
        .req_valid     (req_valid),
        .req_va        (req_va),
        .resp_valid    (resp_valid),
        .resp_hit      (resp_hit),
        .resp_tlb_miss (resp_tlb_miss),
        .resp_way      (resp_way),
        .resp_data     (resp_data),
        .tlb_wr_valid  (tlb_wr_valid),
        .tlb_wr_vpn    (tlb_wr_vpn),
        .tlb_wr_pfn    (tlb_wr_pfn),
        .fill_valid    (fill_valid),
        .fill_pa       (fill_pa),
        .fill_line     (fill_line)
    );

    function automatic logic [31:0] pat(input int pfn, input int set, input int k, input int gen);
        return 32'hC0DE0000 + 32'(pfn * 4096 + set * 256 + k * 16 + gen);
    endfunction

    function automatic logic [LINE_W-1:0] mk_line(input int pfn, input int set, input int gen);
        logic [LINE_W-1:0] l;
        for (int k = 0; k < 4; k++) l[k*32 +: 32] = pat(pfn, set, k, gen);
        return l;
    endfunction

    function automatic logic [VA_BITS-1:0] mk_va(input int vpn, input int set, input int k, input int b);
        return {4'(vpn), 2'(set), 2'(k), 2'(b)};
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic lookup(input logic [VA_BITS-1:0] va);
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(resp_valid == 1'b0, "R2 early", 64'(resp_valid), 64'd0);
        @(negedge clk);
        g_valid = resp_valid;
        g_hit   = resp_hit;
        g_tm    = resp_tlb_miss;
        g_way   = resp_way;
        g_data  = resp_data;
        chk(g_valid == 1'b1, "R2 valid", 64'(g_valid), 64'd1);
    endtask

    // exp_tm, exp_hit, way and data (way/data zero on miss, R10)
    task automatic expect_lk(input logic [VA_BITS-1:0] va, input bit tm, input bit hit,
                             input bit way, input logic [31:0] data, input string rq);
        lookup(va);
        chk(g_tm == tm, rq, 64'(g_tm), 64'(tm));
        chk(g_hit == hit, rq, 64'(g_hit), 64'(hit));
        chk(g_way == way, rq, 64'(g_way), 64'(way));
        chk(g_data == data, rq, 64'(g_data), 64'(data));
    endtask

    task automatic tlb_write(input int vpn, input int pfn);
        @(negedge clk);
        tlb_wr_valid = 1'b1;
        tlb_wr_vpn   = 4'(vpn);
        tlb_wr_pfn   = 3'(pfn);
        @(negedge clk);
        tlb_wr_valid = 1'b0;
    endtask

    task automatic fill(input int pfn, input int set, input int gen, input int junk);
        @(negedge clk);
        fill_valid = 1'b1;
        fill_pa    = {3'(pfn), 2'(set), 4'(junk)};
        fill_line  = mk_line(pfn, set, gen);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int mdl [2];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(resp_valid == 1'b0, "R1 idle", 64'(resp_valid), 64'd0);
        expect_lk(mk_va(3, 0, 0, 0), 1'b1, 1'b0, 1'b0, 32'd0, "R1 empty");

        // R5: translation miss
        expect_lk(mk_va(3, 2, 1, 0), 1'b1, 1'b0, 1'b0, 32'd0, "R5 tlb miss");

        // R4: translation hits but nothing cached
        tlb_write(3, 5);
        for (int s = 0; s < 4; s++)
            expect_lk(mk_va(3, s, 0, 0), 1'b0, 1'b0, 1'b0, 32'd0, "R4 cold miss");

        // R7: fill every set, lowest invalid way 0; offset bits of fill_pa ignored
        for (int s = 0; s < 4; s++) fill(5, s, 0, s * 3 + 1);
        // R10: every word of every set, byte bits varied
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 4; k++)
                expect_lk(mk_va(3, s, k, k), 1'b0, 1'b1, 1'b0, pat(5, s, k, 0), "R10 word sweep");

        // R3: synonym page maps to the same frame
        tlb_write(9, 5);
        for (int s = 0; s < 4; s++)
            expect_lk(mk_va(9, s, 3, 0), 1'b0, 1'b1, 1'b0, pat(5, s, 3, 0), "R3 synonym");

        // R5: line present but page unmapped, then replay
        expect_lk(mk_va(2, 0, 1, 0), 1'b1, 1'b0, 1'b0, 32'd0, "R5 no xlat");
        tlb_write(2, 5);
        expect_lk(mk_va(2, 0, 1, 0), 1'b0, 1'b1, 1'b0, pat(5, 0, 1, 0), "R5 replay");
        // R6: pointer 0 replaced entry holding vpn 3
        expect_lk(mk_va(3, 0, 1, 0), 1'b1, 1'b0, 1'b0, 32'd0, "R6 rr evict");
        expect_lk(mk_va(9, 0, 1, 0), 1'b0, 1'b1, 1'b0, pat(5, 0, 1, 0), "R6 rr keep");
        // R6: same-page overwrite keeps pointer
        tlb_write(9, 6);
        expect_lk(mk_va(9, 0, 1, 0), 1'b0, 1'b0, 1'b0, 32'd0, "R6 overwrite");
        expect_lk(mk_va(2, 0, 1, 0), 1'b0, 1'b1, 1'b0, pat(5, 0, 1, 0), "R6 overwrite keep");
        tlb_write(4, 6); // pointer now 1 -> replaces vpn 9
        expect_lk(mk_va(9, 0, 1, 0), 1'b1, 1'b0, 1'b0, 32'd0, "R6 ptr advance");
        expect_lk(mk_va(2, 1, 1, 0), 1'b0, 1'b1, 1'b0, pat(5, 1, 1, 0), "R6 ptr keep");

        // R7: second tag into set 0 lands in invalid way 1
        fill(6, 0, 0, 0);
        expect_lk(mk_va(4, 0, 2, 0), 1'b0, 1'b1, 1'b1, pat(6, 0, 2, 0), "R7 invalid way");
        // R9: refill of same tag reuses way 1
        fill(6, 0, 1, 0);
        expect_lk(mk_va(4, 0, 2, 0), 1'b0, 1'b1, 1'b1, pat(6, 0, 2, 1), "R9 same tag");
        expect_lk(mk_va(2, 0, 2, 0), 1'b0, 1'b1, 1'b0, pat(5, 0, 2, 0), "R9 other way");

        // R7/R9: full set, LFSR choice; model follows the reported way
        mdl[0] = 5;
        mdl[1] = 6;
        for (int r = 0; r < 6; r++) begin
            int np, w, ev;
            np = 5;
            while (np == mdl[0] || np == mdl[1]) np++;
            tlb_write(4, np);
            fill(np, 0, r + 2, 0);
            lookup(mk_va(4, 0, 0, 0));
            chk(g_hit == 1'b1, "R7 full fill hit", 64'(g_hit), 64'd1);
            chk(g_data == pat(np, 0, 0, r + 2), "R7 full fill data", 64'(g_data), 64'(pat(np, 0, 0, r + 2)));
            w = int'(g_way);
            ev = mdl[w];
            mdl[w] = np;
            tlb_write(4, mdl[1 - w]);
            lookup(mk_va(4, 0, 1, 0));
            chk(g_hit == 1'b1 && g_way == 1'(1 - w), "R9 survivor", 64'(g_way), 64'(1 - w));
            tlb_write(4, ev);
            expect_lk(mk_va(4, 0, 1, 0), 1'b0, 1'b0, 1'b0, 32'd0, "R7 evicted");
        end
        expect_lk(mk_va(2, 3, 0, 0), 1'b0, 1'b1, 1'b0, pat(5, 3, 0, 0), "R7 other sets");

        // R8: flush, and a fill/write in the flush cycle is dropped
        @(negedge clk);
        flush        = 1'b1;
        fill_valid   = 1'b1;
        fill_pa      = {3'd7, 2'd2, 4'd0};
        fill_line    = mk_line(7, 2, 9);
        tlb_wr_valid = 1'b1;
        tlb_wr_vpn   = 4'd7;
        tlb_wr_pfn   = 3'd7;
        @(negedge clk);
        flush        = 1'b0;
        fill_valid   = 1'b0;
        tlb_wr_valid = 1'b0;
        expect_lk(mk_va(2, 1, 0, 0), 1'b1, 1'b0, 1'b0, 32'd0, "R8 tlb cleared");
        expect_lk(mk_va(7, 2, 0, 0), 1'b1, 1'b0, 1'b0, 32'd0, "R8 write dropped");
        tlb_write(2, 5);
        expect_lk(mk_va(2, 1, 0, 0), 1'b0, 1'b0, 1'b0, 32'd0, "R8 lines cleared");
        tlb_write(7, 7);
        expect_lk(mk_va(7, 2, 0, 0), 1'b0, 1'b0, 1'b0, 32'd0, "R8 fill dropped");
        fill(5, 1, 4, 0);
        expect_lk(mk_va(2, 1, 2, 0), 1'b0, 1'b1, 1'b0, pat(5, 1, 2, 4), "R8 refill way0");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule